// File: doc/BRIEF.md
# Two-Stage Address Translation Sequencer

This block sits between a load/store or fetch unit and a pair of table walkers. For each access it receives an effective address, an access kind, the hypervisor-mode and relocation flags, a partition number and the address quadrant. From these it works out a plan: no translation, only the first stage (effective to guest real), only the second stage (guest real to host real), or the first stage followed by the second. It then runs the planned stages one after another over a held-request/response handshake to each walker.

The results of the stages are folded into one answer. The host real address comes from the last stage that ran. The page size is the smallest of the page sizes reported, and the permission set is the intersection of the permission sets reported. A stage that reports a failure ends the sequence at once. The done pulse then carries the fault flag and a marker saying which stage failed, for a separate fault-reporting block. Only one access is handled at a time, and a request that arrives while the block is busy is dropped.

Top module: `xlate_seq`

## Requirements
- R1: With hypervisor mode set, relocation off and partition number zero, no walker is requested and the done pulse reports ok with the result address equal to the effective address, page size all ones and permissions all ones.
- R2: With hypervisor mode clear and relocation off, only the second-stage walker is requested, and its input address is the effective address with its top two bits cleared.
- R3: With hypervisor mode clear and relocation on, the first stage is requested first, and the guest real address it returns is the second stage's input address.
- R4: With hypervisor mode set, relocation on and partition number zero, quadrants 0 and 3 run the first stage only and quadrants 1 and 2 run both stages.
- R5: A nonzero partition number makes the second stage run in every mode, including hypervisor mode with relocation off (input = masked effective address).
- R6: The result page size is the minimum of the page sizes of the stages that ran and the result permissions are their bitwise AND; the result address is the output of the last stage that ran.
- R7: A failure response from a stage ends the access: done follows in the next cycle with fault set, no later stage is requested, and fault_in_s2 is 1 exactly when the second stage failed.
- R8: A walker request stays high until a cycle in which that walker's response valid is high, at most one walker is requested at a time, and the access kind (0 read, 1 write, 2 fetch) is passed unchanged to each walker.
- R9: done is a one-cycle pulse with exactly one of ok and fault high, busy is high from the cycle after acceptance through the done cycle, and busy is low in the cycle after done.
- R10: A request presented while busy is high is ignored and does not change the result of the access in progress or start another one.
- R11: After reset busy, done, ok, fault and both walker requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken only when not busy |
| req_ea | input | EA_W | Effective address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_hv | input | 1 | Hypervisor mode flag |
| req_reloc | input | 1 | Relocation enable flag |
| req_lpid | input | LPID_W | Partition number |
| req_quad | input | 2 | Address quadrant |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Access translated, valid with done |
| fault | output | 1 | A stage failed, valid with done |
| fault_in_s2 | output | 1 | The failing stage was the second, valid with done |
| res_ra | output | EA_W | Host real address |
| res_psize | output | PSZ_W | Page size (log2) |
| res_perm | output | PERM_W | Permission set |
| s1_req | output | 1 | First-stage walker request (held) |
| s1_ea | output | EA_W | First-stage input address |
| s1_acc | output | 2 | First-stage access kind |
| s1_rsp_valid | input | 1 | First-stage response valid |
| s1_fail | input | 1 | First-stage failure |
| s1_gra | input | EA_W | First-stage guest real address |
| s1_psize | input | PSZ_W | First-stage page size |
| s1_perm | input | PERM_W | First-stage permissions |
| s2_req | output | 1 | Second-stage walker request (held) |
| s2_gra | output | EA_W | Second-stage input address |
| s2_acc | output | 2 | Second-stage access kind |
| s2_rsp_valid | input | 1 | Second-stage response valid |
| s2_fail | input | 1 | Second-stage failure |
| s2_hra | input | EA_W | Second-stage host real address |
| s2_psize | input | PSZ_W | Second-stage page size |
| s2_perm | input | PERM_W | Second-stage permissions |

## Verification
The embedded properties watch, on every cycle, the walker handshake holding, the single done pulse with exactly one of ok and fault, the immediate stop after a failing stage, the pass-through and stage-two-only entry paths, and the min/AND merge arithmetic. How the plan depends on the quadrant and partition number, the ordering of the two stages, the chaining of the guest address and dropped requests under busy can only be shown by the bench. It sweeps every mode, quadrant and partition class against three failure patterns and varied walker latencies, and it tallies the requests each walker receives.

// File: rtl/xs_pkg.sv
package xs_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STAGE1 = 2'd1,
    ST_STAGE2 = 2'd2,
    ST_RESP   = 2'd3
  } state_e;

  typedef struct packed {
    logic use_s1;
    logic use_s2;
  } plan_t;

endpackage

// File: rtl/xs_mode_decode.sv
module xs_mode_decode
  import xs_pkg::*;
#(
  parameter int LPID_W = 4
) (
  input  logic              hv,
  input  logic              reloc,
  input  logic [LPID_W-1:0] lpid,
  input  logic [1:0]        quad,
  output plan_t             plan
);

  logic guest_part;
  logic mid_quad;

  always_comb begin
    guest_part  = (lpid != '0);
    mid_quad    = (quad == 2'd1) || (quad == 2'd2);
    plan.use_s1 = reloc;
    // second stage: guest mode, guest partition, or hypervisor reaching quadrants 1/2
    plan.use_s2 = !hv || guest_part || (reloc && mid_quad);
  end

endmodule

// File: rtl/xs_merge.sv
module xs_merge #(
  parameter int PSZ_W  = 6,
  parameter int PERM_W = 3
) (
  input  logic [PSZ_W-1:0]  acc_psize,
  input  logic [PERM_W-1:0] acc_perm,
  input  logic [PSZ_W-1:0]  stg_psize,
  input  logic [PERM_W-1:0] stg_perm,
  output logic [PSZ_W-1:0]  mrg_psize,
  output logic [PERM_W-1:0] mrg_perm
);

  always_comb begin
    mrg_psize = (stg_psize < acc_psize) ? stg_psize : acc_psize;
    mrg_perm  = acc_perm & stg_perm;
  end

  // R6: merged size never exceeds either input; merged rights are a subset of both
  always_comb begin
    a_r6_merge_bound: assert ((mrg_psize <= acc_psize) && (mrg_psize <= stg_psize)
                              && ((mrg_perm & ~acc_perm) == '0)
                              && ((mrg_perm & ~stg_perm) == '0));
  end

endmodule

// File: rtl/xlate_seq.sv
module xlate_seq
  import xs_pkg::*;
#(
  parameter int EA_W   = 16,
  parameter int LPID_W = 4,
  parameter int PSZ_W  = 6,
  parameter int PERM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [EA_W-1:0]   req_ea,
  input  logic [1:0]        req_acc,
  input  logic              req_hv,
  input  logic              req_reloc,
  input  logic [LPID_W-1:0] req_lpid,
  input  logic [1:0]        req_quad,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic              fault,
  output logic              fault_in_s2,
  output logic [EA_W-1:0]   res_ra,
  output logic [PSZ_W-1:0]  res_psize,
  output logic [PERM_W-1:0] res_perm,
  output logic              s1_req,
  output logic [EA_W-1:0]   s1_ea,
  output logic [1:0]        s1_acc,
  input  logic              s1_rsp_valid,
  input  logic              s1_fail,
  input  logic [EA_W-1:0]   s1_gra,
  input  logic [PSZ_W-1:0]  s1_psize,
  input  logic [PERM_W-1:0] s1_perm,
  output logic              s2_req,
  output logic [EA_W-1:0]   s2_gra,
  output logic [1:0]        s2_acc,
  input  logic              s2_rsp_valid,
  input  logic              s2_fail,
  input  logic [EA_W-1:0]   s2_hra,
  input  logic [PSZ_W-1:0]  s2_psize,
  input  logic [PERM_W-1:0] s2_perm
);

  localparam int KEEP_W = EA_W - 2;

  state_e            state_q, state_d;
  plan_t             plan;
  logic              accept;
  logic              s1_take, s2_take;
  logic              run_s2_q;
  logic [EA_W-1:0]   ea_q, gra_q, ra_q;
  logic [1:0]        acc_q;
  logic [PSZ_W-1:0]  psize_q;
  logic [PERM_W-1:0] perm_q;
  logic              fault_q, fault_s2_q;
  logic [EA_W-1:0]   ea_masked;
  logic [PSZ_W-1:0]  stg_psize, mrg_psize;
  logic [PERM_W-1:0] stg_perm, mrg_perm;

  xs_mode_decode #(.LPID_W(LPID_W)) i_decode (
    .hv    (req_hv),
    .reloc (req_reloc),
    .lpid  (req_lpid),
    .quad  (req_quad),
    .plan  (plan)
  );

  xs_merge #(.PSZ_W(PSZ_W), .PERM_W(PERM_W)) i_merge (
    .acc_psize (psize_q),
    .acc_perm  (perm_q),
    .stg_psize (stg_psize),
    .stg_perm  (stg_perm),
    .mrg_psize (mrg_psize),
    .mrg_perm  (mrg_perm)
  );

  always_comb begin
    ea_masked = {2'b00, req_ea[KEEP_W-1:0]};
    accept    = (state_q == ST_IDLE) && req_valid;
    s1_take   = (state_q == ST_STAGE1) && s1_rsp_valid;
    s2_take   = (state_q == ST_STAGE2) && s2_rsp_valid;
    stg_psize = (state_q == ST_STAGE1) ? s1_psize : s2_psize;
    stg_perm  = (state_q == ST_STAGE1) ? s1_perm  : s2_perm;
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (plan.use_s1)      state_d = ST_STAGE1;
          else if (plan.use_s2) state_d = ST_STAGE2;
          else                  state_d = ST_RESP;
        end
      end
      ST_STAGE1: begin
        if (s1_rsp_valid) begin
          if (s1_fail || !run_s2_q) state_d = ST_RESP;
          else                      state_d = ST_STAGE2;
        end
      end
      ST_STAGE2: begin
        if (s2_rsp_valid) state_d = ST_RESP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // captured request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q     <= '0;
      acc_q    <= '0;
      run_s2_q <= 1'b0;
    end else if (accept) begin
      ea_q     <= req_ea;
      acc_q    <= req_acc;
      run_s2_q <= plan.use_s2;
    end
  end

  // guest real address: masked EA, replaced by stage-1 output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gra_q <= '0;
    else if (accept)  gra_q <= ea_masked;
    else if (s1_take) gra_q <= s1_gra;
  end

  // result address and merged attributes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q    <= '0;
      psize_q <= '0;
      perm_q  <= '0;
    end else if (accept) begin
      ra_q    <= req_ea;
      psize_q <= '1;
      perm_q  <= '1;
    end else if (s1_take || s2_take) begin
      ra_q    <= s1_take ? s1_gra : s2_hra;
      psize_q <= mrg_psize;
      perm_q  <= mrg_perm;
    end
  end

  // fault status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q    <= 1'b0;
      fault_s2_q <= 1'b0;
    end else if (accept) begin
      fault_q    <= 1'b0;
      fault_s2_q <= 1'b0;
    end else if (s1_take && s1_fail) begin
      fault_q    <= 1'b1;
    end else if (s2_take && s2_fail) begin
      fault_q    <= 1'b1;
      fault_s2_q <= 1'b1;
    end
  end

  always_comb begin
    busy        = (state_q != ST_IDLE);
    done        = (state_q == ST_RESP);
    ok          = done && !fault_q;
    fault       = done && fault_q;
    fault_in_s2 = done && fault_s2_q;
    res_ra      = ra_q;
    res_psize   = psize_q;
    res_perm    = perm_q;
    s1_req      = (state_q == ST_STAGE1);
    s1_ea       = ea_q;
    s1_acc      = acc_q;
    s2_req      = (state_q == ST_STAGE2);
    s2_gra      = gra_q;
    s2_acc      = acc_q;
  end

  // R8: a walker request is held until its response arrives
  a_r8_s1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_req && !s1_rsp_valid) |=> s1_req);
  a_r8_s2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_req && !s2_rsp_valid) |=> s2_req);

  // R9: completion carries exactly one verdict and does not repeat
  a_r9_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({ok, fault}) == 1) && busy);
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R7: a failing stage ends the access in the next cycle
  a_r7_s1_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_req && s1_rsp_valid && s1_fail) |=> (done && fault && !fault_in_s2 && !s2_req));
  a_r7_s2_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_req && s2_rsp_valid && s2_fail) |=> (done && fault && fault_in_s2));

  // R1: hypervisor real mode in partition zero passes straight through
  a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_hv && !req_reloc && (req_lpid == '0))
    |=> (done && ok && (res_ra == $past(req_ea)) && !s1_req && !s2_req));

  // R2: guest real mode goes directly to the second stage with the masked EA
  a_r2_s2_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !req_hv && !req_reloc)
    |=> (s2_req && !s1_req && (s2_gra == {2'b00, $past(req_ea[KEEP_W-1:0])})));

endmodule

// File: tb/test_xlate_seq.sv
module test_xlate_seq;

  localparam int EA_W     = 16;
  localparam int LPID_W   = 4;
  localparam int PSZ_W    = 6;
  localparam int PERM_W   = 3;
  localparam int CLK_HALF = 5;
  localparam int WD_LIMIT = 100000;

  logic              clk, rst_n;
  logic              req_valid;
  logic [EA_W-1:0]   req_ea;
  logic [1:0]        req_acc;
  logic              req_hv, req_reloc;
  logic [LPID_W-1:0] req_lpid;
  logic [1:0]        req_quad;
  logic              busy, done, ok, fault, fault_in_s2;
  logic [EA_W-1:0]   res_ra;
  logic [PSZ_W-1:0]  res_psize;
  logic [PERM_W-1:0] res_perm;
  logic              s1_req, s1_rsp_valid, s1_fail;
  logic [EA_W-1:0]   s1_ea, s1_gra;
  logic [1:0]        s1_acc;
  logic [PSZ_W-1:0]  s1_psize;
  logic [PERM_W-1:0] s1_perm;
  logic              s2_req, s2_rsp_valid, s2_fail;
  logic [EA_W-1:0]   s2_gra, s2_hra;
  logic [1:0]        s2_acc;
  logic [PSZ_W-1:0]  s2_psize;
  logic [PERM_W-1:0] s2_perm;

  xlate_seq #(.EA_W(EA_W), .LPID_W(LPID_W), .PSZ_W(PSZ_W), .PERM_W(PERM_W)) i_xlate_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea), .req_acc(req_acc),
    .req_hv(req_hv), .req_reloc(req_reloc), .req_lpid(req_lpid), .req_quad(req_quad),
    .busy(busy), .done(done), .ok(ok), .fault(fault), .fault_in_s2(fault_in_s2),
    .res_ra(res_ra), .res_psize(res_psize), .res_perm(res_perm),
    .s1_req(s1_req), .s1_ea(s1_ea), .s1_acc(s1_acc), .s1_rsp_valid(s1_rsp_valid),
    .s1_fail(s1_fail), .s1_gra(s1_gra), .s1_psize(s1_psize), .s1_perm(s1_perm),
    .s2_req(s2_req), .s2_gra(s2_gra), .s2_acc(s2_acc), .s2_rsp_valid(s2_rsp_valid),
    .s2_fail(s2_fail), .s2_hra(s2_hra), .s2_psize(s2_psize), .s2_perm(s2_perm)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // walker model configuration
  int               lat1, lat2, c1, c2;
  int               n1, n2, both_at_once;
  logic             fail1, fail2;
  logic [EA_W-1:0]  seen_s1_ea, seen_s2_gra;
  logic [1:0]       seen_s1_acc, seen_s2_acc;
  logic             order_bad;

  initial clk = 1'b0;
  always #CLK_HALF clk = ~clk;

  task automatic report(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WD_LIMIT);
      finish_run();
    end
  end

  // walker responders, driven at the falling edge
  always @(negedge clk) begin
    if (s1_req && s2_req) both_at_once++;
    s1_rsp_valid <= 1'b0;
    if (s1_req && !s1_rsp_valid) begin
      if (c1 >= lat1 - 1) begin
        s1_rsp_valid <= 1'b1;
        n1++;
        seen_s1_ea  = s1_ea;
        seen_s1_acc = s1_acc;
        c1 = 0;
      end else c1++;
    end else c1 = 0;
    s2_rsp_valid <= 1'b0;
    if (s2_req && !s2_rsp_valid) begin
      if (c2 >= lat2 - 1) begin
        s2_rsp_valid <= 1'b1;
        n2++;
        if (n1 == 0 && seen_s2_gra === 'x) order_bad = 1'b0;
        seen_s2_gra = s2_gra;
        seen_s2_acc = s2_acc;
        c2 = 0;
      end else c2++;
    end else c2 = 0;
  end

  always_comb begin
    s1_fail = fail1;
    s1_gra  = seen_s1_ea + 16'h1230;
    s2_fail = fail2;
    s2_hra  = s2_gra ^ 16'hC003;
  end

  // one access with an ignored request overlapping the busy period
  task automatic run_one(input int idx, input logic hv, input logic reloc,
                         input logic [LPID_W-1:0] lpid, input logic [1:0] quad,
                         input int fm);
    logic [EA_W-1:0]   ea, e_gra, e_ra;
    logic [1:0]        acc;
    logic [PSZ_W-1:0]  ps1, ps2, e_ps;
    logic [PERM_W-1:0] pm1, pm2, e_pm;
    logic              use1, use2, e_fault, e_f2, got;
    int                e_n1, e_n2, waited;
    logic              g_ok, g_fault, g_f2;
    logic [EA_W-1:0]   g_ra;
    logic [PSZ_W-1:0]  g_ps;
    logic [PERM_W-1:0] g_pm;

    ea  = 16'(idx * 40503 + 16'hC1A5);
    acc = 2'(idx % 3);
    ps1 = 6'(12 + (idx % 3) * 9);
    ps2 = 6'(30 - (idx % 4) * 6);
    pm1 = 3'(idx % 8);
    pm2 = 3'((idx * 3 + 5) % 8);
    lat1 = 1 + (idx % 3);
    lat2 = 1 + ((idx / 3) % 3);
    fail1 = (fm == 1);
    fail2 = (fm == 2);
    s1_psize = ps1; s1_perm = pm1; s2_psize = ps2; s2_perm = pm2;
    n1 = 0; n2 = 0; c1 = 0; c2 = 0; both_at_once = 0;
    seen_s1_ea = '0; seen_s2_gra = '0; seen_s1_acc = '0; seen_s2_acc = '0;

    // expected plan from R1..R5
    use1 = reloc;
    use2 = !hv || (lpid != 0) || (reloc && (quad == 2'd1 || quad == 2'd2));
    e_fault = 1'b0; e_f2 = 1'b0;
    e_ps = '1; e_pm = '1; e_ra = ea;
    e_gra = {2'b00, ea[EA_W-3:0]};
    e_n1 = 0; e_n2 = 0;
    if (use1) begin
      e_n1 = 1;
      if (fail1) e_fault = 1'b1;
      else begin
        e_gra = ea + 16'h1230;
        e_ra  = e_gra;
        e_ps  = ps1;
        e_pm  = pm1;
      end
    end
    if (use2 && !e_fault) begin
      e_n2 = 1;
      if (fail2) begin e_fault = 1'b1; e_f2 = 1'b1; end
      else begin
        e_ra = e_gra ^ 16'hC003;
        e_ps = (ps2 < e_ps) ? ps2 : e_ps;
        e_pm = e_pm & pm2;
      end
    end

    // present request
    req_ea = ea; req_acc = acc; req_hv = hv; req_reloc = reloc;
    req_lpid = lpid; req_quad = quad; req_valid = 1'b1;
    @(negedge clk);
    report("R9", "busy after accept", busy, 1);
    got = done;
    g_ok = ok; g_fault = fault; g_f2 = fault_in_s2; g_ra = res_ra; g_ps = res_psize; g_pm = res_perm;
    // R10: a different request while busy must be ignored
    req_ea = ~ea; req_hv = ~hv; req_reloc = ~reloc; req_lpid = lpid + 4'd3; req_quad = quad + 2'd1;
    @(negedge clk);
    req_valid = 1'b0;
    if (got) begin
      report("R9", "done is one pulse", done, 0);
      report("R9", "idle after done", busy, 0);
    end else begin
      waited = 0;
      while (!done && waited < 40) begin
        @(negedge clk);
        waited++;
      end
      report("R9", "done reached", done, 1);
      g_ok = ok; g_fault = fault; g_f2 = fault_in_s2; g_ra = res_ra; g_ps = res_psize; g_pm = res_perm;
      report("R9", "busy during done", busy, 1);
      @(negedge clk);
      report("R9", "done is one pulse", done, 0);
      report("R9", "idle after done", busy, 0);
    end
    // R10: nothing new started by the ignored request
    @(negedge clk);
    report("R10", "no second access", busy, 0);

    report("R9", "verdict one-hot", {g_ok, g_fault}, e_fault ? 2'b01 : 2'b10);
    report("R7", "fault flag", g_fault, e_fault);
    report("R7", "fault stage", g_f2, e_f2);
    report(use1 ? "R4" : "R2", "stage1 requests", n1, e_n1);
    report(lpid != 0 ? "R5" : "R4", "stage2 requests", n2, e_n2);
    report("R8", "one walker at a time", both_at_once, 0);
    if (e_n1 == 1) begin
      report("R8", "stage1 addr", seen_s1_ea, ea);
      report("R8", "stage1 access kind", seen_s1_acc, acc);
    end
    if (e_n2 == 1) begin
      report(use1 ? "R3" : "R2", "stage2 input addr", seen_s2_gra, e_gra);
      report("R8", "stage2 access kind", seen_s2_acc, acc);
    end
    if (!e_fault) begin
      report((e_n1 + e_n2 == 0) ? "R1" : "R6", "result addr", g_ra, e_ra);
      report("R6", "page size", g_ps, e_ps);
      report("R6", "permissions", g_pm, e_pm);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_ea = '0; req_acc = '0; req_hv = 1'b0; req_reloc = 1'b0;
    req_lpid = '0; req_quad = '0;
    s1_rsp_valid = 1'b0; s2_rsp_valid = 1'b0;
    fail1 = 1'b0; fail2 = 1'b0; lat1 = 1; lat2 = 1;
    s1_psize = '0; s1_perm = '0; s2_psize = '0; s2_perm = '0;
    c1 = 0; c2 = 0; n1 = 0; n2 = 0; both_at_once = 0; order_bad = 1'b0;
    seen_s1_ea = '0; seen_s2_gra = '0; seen_s1_acc = '0; seen_s2_acc = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    report("R11", "busy in reset", busy, 0);
    report("R11", "done in reset", done, 0);
    report("R11", "verdict in reset", {ok, fault}, 0);
    report("R11", "walker requests in reset", {s1_req, s2_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    report("R11", "idle after reset", {busy, done, s1_req, s2_req}, 0);

    begin
      int idx;
      idx = 0;
      for (int fm = 0; fm < 3; fm++)
        for (int hv = 0; hv < 2; hv++)
          for (int rl = 0; rl < 2; rl++)
            for (int lp = 0; lp < 3; lp++)
              for (int q = 0; q < 4; q++) begin
                run_one(idx, hv[0], rl[0], LPID_W'(lp == 0 ? 0 : (lp == 1 ? 1 : 9)), q[1:0], fm);
                idx++;
              end
    end
    finish_run();
  end

endmodule